// File: doc/BRIEF.md
# Tagged Receive Silo for a Sixteen-Line Serial Multiplexer

This block collects characters from sixteen serial receivers into one shared first-in first-out store. Each stored entry carries the character, the number of the line it came from, its parity and framing error flags, and an overrun mark. A host drains the store by reading a 16-bit receive word again and again. The top bit of that word is set while an entry is present, so software can keep reading until the value turns non-negative. Each read removes one entry.

Every line has a one-character holding stage. When several lines complete characters together, a fixed-priority arbiter moves one held character per cycle into the store, lowest line number first. A character that cannot be kept is lost, and the next character stored from that line is marked as overrun. This happens when the store is full at the moment the line is served, or when a second character arrives before the first was served. A control word holds two interrupt flags, each with its own enable. The receive flag marks the store going from empty to non-empty. The storage flag marks the fill count reaching a programmable alarm level. A master-clear bit in the same word returns the whole block to its reset state.

Top module: `mux_rx_silo`

## Requirements
- R1: A non-empty read word has bit 15 set, bits 11:8 hold the receiving line number (0 to 15) and bits 7:0 hold the character.
- R2: While the store is empty the read word is 16'h0000, and a read strobe changes nothing.
- R3: Each read strobe on a non-empty store removes exactly one entry, and entries leave in the order they were stored.
- R4: Characters that arrive in the same cycle on several lines are stored in ascending line order, one per cycle.
- R5: Bit 12 of an entry is the parity error flag and bit 13 is the framing error flag given with that character.
- R6: The 2-bit length code of a line (0, 1, 2, 3 for 5, 6, 7, 8 data bits) clears the character bits above the length.
- R7: A character served while 64 entries are held is discarded, and bit 14 is set on the next entry stored from that line and clear on the ones after it.
- R8: A character that arrives while the line's previous character is still waiting replaces it, and the replacing entry has bit 14 set.
- R9: The store holds exactly 64 entries.
- R10: Control bit 7 (receive flag) sets when an entry is stored into an empty store. Writing 0 to bit 7 clears it, and writing 1 leaves it unchanged.
- R11: Control bit 14 (storage flag) sets when a store raises the fill count to the alarm level. The level is a 6-bit value written on its own port and is 16 after reset. Writing 0 to bit 14 clears the flag.
- R12: Control bits 12 and 6 enable the storage and receive flags onto irq. irq is high only while an enabled flag is set.
- R13: Writing 1 to control bit 11 empties the store and drops all waiting characters. It also clears both flags and both enables and sets the alarm level back to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_valid | input | 16 | One-cycle strobe per line: character complete |
| line_data | input | 128 | Character per line, line n at bits 8n+7:8n |
| line_len | input | 32 | Length code per line, line n at bits 2n+1:2n |
| line_perr | input | 16 | Parity error per line, valid with its strobe |
| line_ferr | input | 16 | Framing error per line, valid with its strobe |
| rx_rd | input | 1 | Read strobe: removes the entry shown on rx_data |
| rx_data | output | 16 | Head entry, or zero when empty |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write value |
| csr_rdata | output | 16 | Control word: flags at 14 and 7, enables at 12 and 6 |
| alarm_wr | input | 1 | Alarm level write strobe |
| alarm_wdata | input | 6 | Alarm level write value |
| irq | output | 1 | Interrupt request |

## Verification
Seeded random rounds fire random line masks with random characters, length codes and error bits. Each round runs twice before a drain, so the read order shows both the ascending order within one cycle and first-in first-out order across rounds. Any swapped field or masking error shows up as a mismatched word. Directed cases cover the rest. A fill to exactly 64 entries followed by one more character separates the full-store drop from a normal store. Back-to-back characters on one line separate a hold overwrite from arbitration order. A master clear issued while fifteen characters still wait shows that the holding stages are cleared as well as the store. The two alarm levels each raise the storage flag at their own count and not at the other.

// File: rtl/rxs_pkg.sv
// Shared constants and types for the tagged receive silo.
// Assumes at most 16 lines, since the line tag is a 4-bit field.
package rxs_pkg;
    localparam int CHAR_W  = 8;
    localparam int LINE_W  = 4;
    localparam int ALARM_W = 6;

    // Field positions in the control word
    localparam int CSR_SI  = 14;
    localparam int CSR_SIE = 12;
    localparam int CSR_MC  = 11;
    localparam int CSR_RI  = 7;
    localparam int CSR_RIE = 6;

    // One stored entry. Bit 15 of the read word is added at the output.
    typedef struct packed {
        logic              ovr;
        logic              fe;
        logic              pe;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] data;
    } silo_entry_t;

    localparam int ENTRY_W = $bits(silo_entry_t);

    // Clear the character bits above the length code (0..3 -> 5..8 bits)
    function automatic logic [CHAR_W-1:0] trim_char(input logic [CHAR_W-1:0] d,
                                                    input logic [1:0] len);
        return d & (8'hFF >> (2'd3 - len));
    endfunction
endpackage

// File: rtl/rxs_line_hold.sv
// One-character holding stage for a single line receiver.
// It keeps the latest character until the arbiter serves it, and it keeps a
// sticky loss flag that marks the next stored character after any lost one.
// Assumes that grant is only high while pend is high.
module rxs_line_hold
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_pe,
    input  logic              in_fe,
    input  logic              grant,
    input  logic              full,
    output logic              pend,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_pe,
    output logic              out_fe,
    output logic              out_ovr
);
    // Capture the arriving character and track whether it still waits
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend     <= 1'b0;
            out_data <= '0;
            out_pe   <= 1'b0;
            out_fe   <= 1'b0;
        end else if (in_valid) begin
            pend     <= 1'b1;
            out_data <= in_data;
            out_pe   <= in_pe;
            out_fe   <= in_fe;
        end else if (grant) begin
            pend     <= 1'b0;
        end
    end

    // Sticky loss flag: set by a full-store drop or an overwrite, cleared once stored
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_ovr <= 1'b0;
        end else if (grant) begin
            out_ovr <= full;
        end else if (in_valid && pend) begin
            out_ovr <= 1'b1;
        end
    end
endmodule

// File: rtl/rxs_arbiter.sv
// Fixed-priority selector: picks the lowest-numbered requesting line.
// Purely combinational, with one grant per cycle at most.
module rxs_arbiter #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan upward and stop at the first request
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxs_fifo.sv
// First-in first-out store with an occupancy count.
// Writes while full and reads while empty are ignored. Clear empties it.
module rxs_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 15,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Step a pointer with a wrap at the last slot
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage array write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/rxs_ctrl.sv
// Control word, alarm level and interrupt flags.
// Flags set on store events and are cleared by writing 0 to them. A set event
// wins over a clear in the same cycle. Master clear is a combinational pulse
// decoded from the write, and it resets this block too.
module rxs_ctrl
    import rxs_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int ALARM_RESET = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr,
    input  logic [15:0]        csr_wdata,
    input  logic               alarm_wr,
    input  logic [ALARM_W-1:0] alarm_wdata,
    input  logic               store,
    input  logic               pop_ok,
    input  logic [CNT_W-1:0]   count,
    output logic               clr,
    output logic [15:0]        csr_rdata,
    output logic               irq
);
    logic               si_q, sie_q, ri_q, rie_q;
    logic [ALARM_W-1:0] alarm_q;
    logic               set_si, set_ri, clr_si, clr_ri;
    logic               wdata_unused;

    assign wdata_unused = ^{csr_wdata[15], csr_wdata[13], csr_wdata[10:8], csr_wdata[5:0]};

    assign clr    = csr_wr && csr_wdata[CSR_MC];
    assign set_ri = store && (count == '0);
    assign set_si = store && !pop_ok && ((count + CNT_W'(1)) == CNT_W'(alarm_q));
    assign clr_si = csr_wr && !csr_wdata[CSR_SI];
    assign clr_ri = csr_wr && !csr_wdata[CSR_RI];

    // Register update for enables, flags and alarm level
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            si_q    <= 1'b0;
            sie_q   <= 1'b0;
            ri_q    <= 1'b0;
            rie_q   <= 1'b0;
            alarm_q <= ALARM_W'(ALARM_RESET);
        end else begin
            if (csr_wr) begin
                sie_q <= csr_wdata[CSR_SIE];
                rie_q <= csr_wdata[CSR_RIE];
            end
            si_q <= set_si || (si_q && !clr_si);
            ri_q <= set_ri || (ri_q && !clr_ri);
            if (alarm_wr) alarm_q <= alarm_wdata;
        end
    end

    // Readback view of the control word
    always_comb begin
        csr_rdata          = '0;
        csr_rdata[CSR_SI]  = si_q;
        csr_rdata[CSR_SIE] = sie_q;
        csr_rdata[CSR_RI]  = ri_q;
        csr_rdata[CSR_RIE] = rie_q;
    end

    // Interrupt request from the enabled flags
    assign irq = (si_q && sie_q) || (ri_q && rie_q);
endmodule

// File: rtl/mux_rx_silo.sv
// Top of the tagged receive silo. Per-line holding stages feed a lowest-first
// arbiter that moves one character per cycle into a shared store. The head
// entry is shown on rx_data with a valid flag in bit 15.
// Assumes NUM_LINES <= 16 and line strobes lasting one cycle.
module mux_rx_silo
    import rxs_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int DEPTH       = 64,
    parameter int ALARM_RESET = 16,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_LINES-1:0]      line_valid,
    input  logic [NUM_LINES*8-1:0]    line_data,
    input  logic [NUM_LINES*2-1:0]    line_len,
    input  logic [NUM_LINES-1:0]      line_perr,
    input  logic [NUM_LINES-1:0]      line_ferr,
    input  logic                      rx_rd,
    output logic [15:0]               rx_data,
    input  logic                      csr_wr,
    input  logic [15:0]               csr_wdata,
    output logic [15:0]               csr_rdata,
    input  logic                      alarm_wr,
    input  logic [ALARM_W-1:0]        alarm_wdata,
    output logic                      irq
);
    logic [NUM_LINES-1:0] pend, grant;
    logic [CHAR_W-1:0]    h_data [NUM_LINES];
    logic [NUM_LINES-1:0] h_pe, h_fe, h_ovr;
    logic [LINE_W-1:0]    idx;
    logic                 any, store, full, empty, clr, pop_ok;
    logic [CNT_W-1:0]     count;
    silo_entry_t          wentry, rentry;

    // One holding stage per line, with the character trimmed to its length
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        rxs_line_hold u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .in_valid (line_valid[g]),
            .in_data  (trim_char(line_data[g*8 +: 8], line_len[g*2 +: 2])),
            .in_pe    (line_perr[g]),
            .in_fe    (line_ferr[g]),
            .grant    (grant[g]),
            .full     (full),
            .pend     (pend[g]),
            .out_data (h_data[g]),
            .out_pe   (h_pe[g]),
            .out_fe   (h_fe[g]),
            .out_ovr  (h_ovr[g])
        );
    end

    rxs_arbiter #(.N(NUM_LINES), .IDX_W(LINE_W)) u_arb (
        .req   (pend),
        .grant (grant),
        .idx   (idx),
        .any   (any)
    );

    assign store  = any && !full;
    assign pop_ok = rx_rd && !empty;

    // Format the served character into an entry
    always_comb begin
        wentry.ovr  = h_ovr[idx];
        wentry.fe   = h_fe[idx];
        wentry.pe   = h_pe[idx];
        wentry.line = idx;
        wentry.data = h_data[idx];
    end

    rxs_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (store),
        .wdata (wentry),
        .pop   (rx_rd),
        .rdata (rentry),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    rxs_ctrl #(.CNT_W(CNT_W), .ALARM_RESET(ALARM_RESET)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_wr      (csr_wr),
        .csr_wdata   (csr_wdata),
        .alarm_wr    (alarm_wr),
        .alarm_wdata (alarm_wdata),
        .store       (store),
        .pop_ok      (pop_ok),
        .count       (count),
        .clr         (clr),
        .csr_rdata   (csr_rdata),
        .irq         (irq)
    );

    // Read word: valid flag plus head entry, or zero when empty
    assign rx_data = empty ? 16'h0000 : {1'b1, rentry};
endmodule

// File: rtl/rxs_checker.sv
// Property checker for the tagged receive silo, bound into the top module.
module rxs_checker #(
    parameter int NUM_LINES = 16,
    parameter int DEPTH     = 64,
    parameter int CNT_W     = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CNT_W-1:0]     count,
    input logic                 store,
    input logic [NUM_LINES-1:0] grant,
    input logic                 rx_rd,
    input logic [15:0]          rx_data,
    input logic                 csr_wr,
    input logic [15:0]          csr_wdata,
    input logic [15:0]          csr_rdata,
    input logic                 irq
);
    logic mc;
    assign mc = csr_wr && csr_wdata[11];

    assert_valid_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> rx_data[15]);

    assert_empty_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (rx_data == 16'h0000));

    assert_pop_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && count != '0 && !store && !mc) |=> (count == $past(count) - CNT_W'(1)));

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_rx_flag_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (store && count == '0 && !mc) |=> csr_rdata[7]);

    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rdata[12] && !csr_rdata[6]) |-> !irq);

    assert_master_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mc |=> (count == '0 && csr_rdata == 16'h0000));
endmodule

bind mux_rx_silo rxs_checker #(
    .NUM_LINES (NUM_LINES),
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W)
) u_rxs_checker (.*);

// File: tb/mux_rx_silo_bench.sv
module mux_rx_silo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NL-1:0]  line_valid = '0;
    logic [NL*8-1:0] line_data = '0;
    logic [NL*2-1:0] line_len = '0;
    logic [NL-1:0]  line_perr = '0;
    logic [NL-1:0]  line_ferr = '0;
    logic           rx_rd = 1'b0;
    logic [15:0]    rx_data;
    logic           csr_wr = 1'b0;
    logic [15:0]    csr_wdata = '0;
    logic [15:0]    csr_rdata;
    logic           alarm_wr = 1'b0;
    logic [5:0]     alarm_wdata = '0;
    logic           irq;

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_rx_silo u_mux_rx_silo (.*);

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (20) tick();
    endtask

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        case (len)
            2'd0: return 8'h1F;
            2'd1: return 8'h3F;
            2'd2: return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    // One cycle of arrivals with random content, queued in ascending line order
    task automatic do_round(input logic [15:0] mask, input bit keep, input logic [15:0] ovr_mask);
        for (int i = 0; i < NL; i++) begin
            logic [7:0] d;
            logic [1:0] ln;
            logic pe, fe;
            d  = 8'($urandom);
            ln = 2'($urandom);
            pe = 1'($urandom);
            fe = 1'($urandom);
            line_data[i*8 +: 8] = d;
            line_len[i*2 +: 2]  = ln;
            line_perr[i] = pe;
            line_ferr[i] = fe;
            if (mask[i] && keep)
                exp_q.push_back({1'b1, ovr_mask[i], fe, pe, 4'(i), d & len_mask(ln)});
        end
        line_valid = mask;
        tick();
        line_valid = '0;
    endtask

    task automatic csr_write(input logic [15:0] v);
        csr_wr = 1'b1;
        csr_wdata = v;
        tick();
        csr_wr = 1'b0;
    endtask

    task automatic alarm_write(input logic [5:0] v);
        alarm_wr = 1'b1;
        alarm_wdata = v;
        tick();
        alarm_wr = 1'b0;
    endtask

    task automatic read_one(input string req);
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, req, rx_data, e);
        rx_rd = 1'b1;
        tick();
        rx_rd = 1'b0;
    endtask

    // Drain everything expected, then confirm the store reads empty
    task automatic read_all(input string req);
        while (exp_q.size() > 0) read_one(req);
        check(rx_data == 16'h0000, "R2 empty after drain", rx_data, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2 R12: reset state
        check(rx_data == 16'h0000, "R2 reset read", rx_data, 16'h0000);
        check(csr_rdata == 16'h0000, "R12 reset control", csr_rdata, 16'h0000);
        check(irq == 1'b0, "R12 reset irq", 16'(irq), 16'h0);
        rx_rd = 1'b1; tick(); rx_rd = 1'b0;
        check(rx_data == 16'h0000, "R2 read on empty", rx_data, 16'h0000);

        // R10 R12: receive flag and its enable
        csr_write(16'h0040);
        do_round(16'h0200, 1'b1, 16'h0);
        settle();
        check(csr_rdata == 16'h00C0, "R10 receive flag set", csr_rdata, 16'h00C0);
        check(irq == 1'b1, "R12 irq from receive flag", 16'(irq), 16'h1);
        csr_write(16'h00C0);
        check(csr_rdata[7] == 1'b1, "R10 write 1 keeps flag", csr_rdata, 16'h00C0);
        csr_write(16'h0080);
        check(irq == 1'b0, "R12 disabled flag gives no irq", 16'(irq), 16'h0);
        csr_write(16'h0000);
        check(csr_rdata == 16'h0000, "R10 write 0 clears flag", csr_rdata, 16'h0000);
        read_all("R1 single entry format");

        // R3 R4 R5 R6: random rounds, two per drain
        for (int r = 0; r < 10; r++) begin
            logic [15:0] m1, m2;
            m1 = 16'($urandom);
            m2 = 16'($urandom);
            if (m1 == 0) m1 = 16'h8001;
            do_round(m1, 1'b1, 16'h0);
            settle();
            do_round(m2, 1'b1, 16'h0);
            settle();
            read_all("R4 ascending order, R3 FIFO, R5 flags, R6 trim");
        end

        // R11: alarm at the reset level 16, then at 20
        csr_write(16'h1000);
        do_round(16'h7FFF, 1'b1, 16'h0);
        settle();
        check(csr_rdata[14] == 1'b0, "R11 no storage flag at 15", csr_rdata, 16'h1000);
        do_round(16'h8000, 1'b1, 16'h0);
        settle();
        check(csr_rdata[14] == 1'b1, "R11 storage flag at 16", csr_rdata, 16'h5000);
        check(irq == 1'b1, "R12 irq from storage flag", 16'(irq), 16'h1);
        alarm_write(6'd20);
        csr_write(16'h1000);
        check(csr_rdata[14] == 1'b0, "R11 storage flag cleared", csr_rdata, 16'h1000);
        do_round(16'h0007, 1'b1, 16'h0);
        settle();
        check(csr_rdata[14] == 1'b0, "R11 no flag at 19", csr_rdata, 16'h1000);
        do_round(16'h0100, 1'b1, 16'h0);
        settle();
        check(csr_rdata[14] == 1'b1, "R11 flag at written level 20", csr_rdata, 16'h5000);
        read_all("R3 drain after alarm test");
        csr_write(16'h0000);

        // R7 R9: fill to 64, drop one on line 3, next line-3 entry marked
        for (int k = 0; k < 4; k++) begin
            do_round(16'hFFFF, 1'b1, 16'h0);
            settle();
        end
        do_round(16'h0008, 1'b0, 16'h0);
        settle();
        read_one("R9 head of full store");
        do_round(16'h0008, 1'b1, 16'h0008);
        settle();
        read_all("R9 64 kept entries, R7 overrun mark");
        do_round(16'h0008, 1'b1, 16'h0);
        settle();
        read_all("R7 overrun mark cleared after use");

        // R8: overwrite of a waiting character on line 5
        do_round(16'h003F, 1'b1, 16'h0);
        void'(exp_q.pop_back());
        do_round(16'h0020, 1'b1, 16'h0020);
        settle();
        read_all("R8 overwrite marked as overrun");

        // R13: master clear with characters still waiting
        csr_write(16'h1040);
        do_round(16'hFFFF, 1'b0, 16'h0);
        csr_write(16'h0800);
        settle();
        check(rx_data == 16'h0000, "R13 store emptied", rx_data, 16'h0000);
        check(csr_rdata == 16'h0000, "R13 control cleared", csr_rdata, 16'h0000);
        check(irq == 1'b0, "R13 irq low", 16'(irq), 16'h0);
        csr_write(16'h1000);
        do_round(16'h7FFF, 1'b1, 16'h0);
        do_round(16'h8000, 1'b1, 16'h0);
        settle();
        check(csr_rdata[14] == 1'b1, "R13 alarm back to 16", csr_rdata, 16'h5000);
        read_all("R13 store usable after clear");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule